// File: doc/BRIEF.md
# Pipeline Squash and Trap Steering Controller

This block sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it decides which of the four pipeline registers must take a bubble instead of the instruction arriving at it, and where fetch goes next. There are two causes of a squash. The first is a branch redirect that was resolved early, together with its target. The second is a fault flag from any of the four stages that sit ahead of writeback, each flag carrying the PC of the instruction that raised it.

A branch redirect squashes only the instruction entering the fetch/decode register, and fetch moves to the target. A fault is handled precisely. The instruction that raised it is squashed along with every younger instruction, and all older instructions carry on to writeback. Its PC is stored in a fault-PC register, and fetch moves to a fixed handler address. The block decides neither branch direction nor fault cause. It does not implement the handler either.

Every flush, gated write-enable and next-PC output is combinational, so the pipeline can apply it at the edge that closes the current cycle. The fault-PC register is the only state in the block. All of its pins are plain control and status pins, with no handshake.

Top module: `pipe_squash_ctrl`

## Requirements
- R1: With a branch redirect and no fault flag set, `flush` is 4'b0001. Bit 0 is the fetch/decode register, bit 1 decode/execute, bit 2 execute/memory and bit 3 memory/writeback.
- R2: With a branch redirect and no fault flag set, `pc_sel` is 2'd1 and `next_pc` equals `br_target` in the same cycle.
- R3: With no redirect and no fault flag set, `pc_sel` is 2'd0, `next_pc` equals `seq_pc` and `flush` is zero.
- R4: A fault taken from stage s (0 fetch, 1 decode, 2 execute, 3 memory) sets flush bits 0 through s.
- R5: A fault taken from stage s leaves flush bits above s clear, so older instructions drain.
- R6: When a fault is taken, `trap_redirect` is 1, `pc_sel` is 2'd2 and `next_pc` equals the parameter HANDLER_PC in the same cycle. Otherwise `trap_redirect` is 0.
- R7: The PC of the taken fault appears on `fault_pc_q` one clock edge later. The register holds its value on every edge without a taken fault.
- R8: When a fault and a branch redirect occur in the same cycle, the fault wins, and R4 to R6 apply unchanged.
- R9: When several fault flags are set, only the one with the highest stage index (the oldest instruction) is taken.
- R10: `rf_we_out[r]` equals `rf_we_in[r] & ~flush[r]`, and `mem_we_out[r]` equals `mem_we_in[r] & ~flush[r]`, so a squashed slot writes neither the register file nor memory.
- R11: While `rst_n` is low, `fault_pc_q` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_pc | input | 32 | Sequential next fetch address |
| br_redirect | input | 1 | Early-resolved branch needs a redirect |
| br_target | input | 32 | Correct-path branch target |
| exc_flag | input | 4 | Fault raised, one bit per stage, bit 0 fetch to bit 3 memory |
| exc_pc | input | 4x32 | PC of the instruction in each stage |
| rf_we_in | input | 4 | Register-write control about to enter each pipeline register |
| mem_we_in | input | 4 | Memory-write control about to enter each pipeline register |
| flush | output | 4 | Load a bubble into this pipeline register |
| rf_we_out | output | 4 | Gated register-write controls |
| mem_we_out | output | 4 | Gated memory-write controls |
| pc_sel | output | 2 | 0 sequential, 1 branch, 2 handler |
| next_pc | output | 32 | Next fetch address |
| trap_redirect | output | 1 | Fault taken this cycle |
| fault_pc_q | output | 32 | Saved PC of the last taken fault |

## Verification
Flush, gated write-enable, `pc_sel`, `next_pc` and `trap_redirect` all depend on their inputs through logic only. They are due in the same cycle as the stimulus. The bench drives on the falling edge and samples a few nanoseconds later, still before the rising edge. `fault_pc_q` is due one rising edge after a taken fault, so the bench checks it 1 ns after that edge, against a model that updates only on taken faults. The sweep covers all 16 fault-flag combinations, with and without a branch, over several PC bases.

// File: rtl/squash_pkg.sv
package squash_pkg;
  typedef enum logic [1:0] {
    PCS_SEQ    = 2'd0,
    PCS_BRANCH = 2'd1,
    PCS_TRAP   = 2'd2
  } pc_src_e;
endpackage

// File: rtl/fault_pick.sv
module fault_pick #(
  parameter int NSTG = 4,
  parameter int XLEN = 32,
  parameter int IDXW = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSTG-1:0]            flag,
  input  logic [NSTG-1:0][XLEN-1:0]  stage_pc,
  output logic                       take,
  output logic [IDXW-1:0]            idx,
  output logic [XLEN-1:0]            pick_pc
);
  // Ascending scan: the highest (oldest) set stage overwrites lower ones.
  always_comb begin
    take    = 1'b0;
    idx     = '0;
    pick_pc = '0;
    for (int s = 0; s < NSTG; s++) begin
      if (flag[s]) begin
        take    = 1'b1;
        idx     = IDXW'(s);
        pick_pc = stage_pc[s];
      end
    end
  end

  AST_PICK_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ((flag >> idx) == NSTG'(1)));  // R9
endmodule

// File: rtl/squash_mask.sv
module squash_mask #(
  parameter int NSTG = 4,
  parameter int IDXW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [IDXW-1:0] idx,
  input  logic            br_req,
  input  logic [NSTG-1:0] rf_we_in,
  input  logic [NSTG-1:0] mem_we_in,
  output logic [NSTG-1:0] flush,
  output logic [NSTG-1:0] rf_we_out,
  output logic [NSTG-1:0] mem_we_out
);
  genvar r;
  generate
    for (r = 0; r < NSTG; r++) begin : g_slot
      if (r == 0) begin : g_young
        assign flush[r] = take | br_req;
      end else begin : g_older
        assign flush[r] = take & (int'(idx) >= r);
      end
    end
  endgenerate

  assign rf_we_out  = rf_we_in  & ~flush;
  assign mem_we_out = mem_we_in & ~flush;

  AST_YOUNGEST_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> flush[0]);  // R4
  AST_OLDER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ((flush >> idx) == NSTG'(1)));  // R5
  AST_BRANCH_ONLY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (br_req && !take) |-> (flush == NSTG'(1)));  // R1
endmodule

// File: rtl/pc_steer.sv
module pc_steer
  import squash_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter logic [31:0] HANDLER_PC = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            br_req,
  input  logic [XLEN-1:0] br_target,
  input  logic [XLEN-1:0] seq_pc,
  input  logic [XLEN-1:0] fault_pc,
  output logic [XLEN-1:0] next_pc,
  output logic [1:0]      pc_sel,
  output logic            trap_redirect,
  output logic [XLEN-1:0] fault_pc_q
);
  pc_src_e src;

  always_comb begin
    if (take)        src = PCS_TRAP;
    else if (br_req) src = PCS_BRANCH;
    else             src = PCS_SEQ;
  end

  always_comb begin
    unique case (src)
      PCS_TRAP:   next_pc = XLEN'(HANDLER_PC);
      PCS_BRANCH: next_pc = br_target;
      default:    next_pc = seq_pc;
    endcase
  end

  assign pc_sel        = src;
  assign trap_redirect = take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fault_pc_q <= '0;
    else if (take) fault_pc_q <= fault_pc;
  end

  AST_FAULT_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(fault_pc_q));  // R7
  AST_TRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && br_req) |-> (next_pc == XLEN'(HANDLER_PC)));  // R8
  AST_TRAP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    trap_redirect |-> (pc_sel == 2'd2));  // R6
endmodule

// File: rtl/pipe_squash_ctrl.sv
module pipe_squash_ctrl #(
  parameter int          XLEN       = 32,
  parameter int          NSTG       = 4,
  parameter logic [31:0] HANDLER_PC = 32'h0000_0100
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [XLEN-1:0]            seq_pc,
  input  logic                       br_redirect,
  input  logic [XLEN-1:0]            br_target,
  input  logic [NSTG-1:0]            exc_flag,
  input  logic [NSTG-1:0][XLEN-1:0]  exc_pc,
  input  logic [NSTG-1:0]            rf_we_in,
  input  logic [NSTG-1:0]            mem_we_in,
  output logic [NSTG-1:0]            flush,
  output logic [NSTG-1:0]            rf_we_out,
  output logic [NSTG-1:0]            mem_we_out,
  output logic [1:0]                 pc_sel,
  output logic [XLEN-1:0]            next_pc,
  output logic                       trap_redirect,
  output logic [XLEN-1:0]            fault_pc_q
);
  localparam int IDXW = (NSTG > 1) ? $clog2(NSTG) : 1;

  logic            take;
  logic [IDXW-1:0] idx;
  logic [XLEN-1:0] pick_pc;

  fault_pick #(.NSTG(NSTG), .XLEN(XLEN), .IDXW(IDXW)) i_pick (
    .clk(clk), .rst_n(rst_n), .flag(exc_flag), .stage_pc(exc_pc),
    .take(take), .idx(idx), .pick_pc(pick_pc)
  );

  squash_mask #(.NSTG(NSTG), .IDXW(IDXW)) i_mask (
    .clk(clk), .rst_n(rst_n), .take(take), .idx(idx), .br_req(br_redirect),
    .rf_we_in(rf_we_in), .mem_we_in(mem_we_in),
    .flush(flush), .rf_we_out(rf_we_out), .mem_we_out(mem_we_out)
  );

  pc_steer #(.XLEN(XLEN), .HANDLER_PC(HANDLER_PC)) i_steer (
    .clk(clk), .rst_n(rst_n), .take(take), .br_req(br_redirect),
    .br_target(br_target), .seq_pc(seq_pc), .fault_pc(pick_pc),
    .next_pc(next_pc), .pc_sel(pc_sel), .trap_redirect(trap_redirect),
    .fault_pc_q(fault_pc_q)
  );

  AST_NO_SQUASHED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((flush & (rf_we_out | mem_we_out)) == '0));  // R10
  AST_IDLE_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_flag == '0 && !br_redirect) |-> (next_pc == seq_pc && flush == '0));  // R3
  AST_TRAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_flag == NSTG'(1)) |=> (fault_pc_q == $past(exc_pc[0])));  // R7
endmodule

// File: tb/test_pipe_squash_ctrl.sv
module test_pipe_squash_ctrl;
  localparam logic [31:0] HPC = 32'h0000_0100;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [31:0]       seq_pc = '0, br_target = '0;
  logic              br_redirect = 1'b0;
  logic [3:0]        exc_flag = '0, rf_we_in = '0, mem_we_in = '0;
  logic [3:0][31:0]  exc_pc = '0;
  logic [3:0]        flush, rf_we_out, mem_we_out;
  logic [1:0]        pc_sel;
  logic [31:0]       next_pc, fault_pc_q;
  logic              trap_redirect;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_epc = '0;

  always #10 clk = ~clk;

  pipe_squash_ctrl #(.XLEN(32), .NSTG(4), .HANDLER_PC(HPC)) i_pipe_squash_ctrl (
    .clk(clk), .rst_n(rst_n), .seq_pc(seq_pc), .br_redirect(br_redirect),
    .br_target(br_target), .exc_flag(exc_flag), .exc_pc(exc_pc),
    .rf_we_in(rf_we_in), .mem_we_in(mem_we_in), .flush(flush),
    .rf_we_out(rf_we_out), .mem_we_out(mem_we_out), .pc_sel(pc_sel),
    .next_pc(next_pc), .trap_redirect(trap_redirect), .fault_pc_q(fault_pc_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R11 reset fault_pc_q", fault_pc_q, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    for (int base = 0; base < 4; base++) begin
      for (int v = 0; v < 32; v++) begin
        logic [3:0] f;
        logic       b;
        int         old;
        logic [3:0] ef;
        logic [31:0] epc_new;
        f = v[3:0];
        b = v[4];
        @(negedge clk);
        exc_flag    = f;
        br_redirect = b;
        seq_pc      = 32'h0000_2000 + base * 32'h40 + v * 4;
        br_target   = 32'h0000_8000 ^ (v * 32'h10 + base);
        for (int s = 0; s < 4; s++) exc_pc[s] = 32'h1000_0000 + base * 32'h1000 + v * 32'h20 + s * 4;
        rf_we_in  = 4'hF ^ v[3:0] ^ base[3:0];
        mem_we_in = ~v[3:0] | base[3:0];
        old = -1;
        for (int s = 0; s < 4; s++) if (f[s]) old = s;
        if (old >= 0)  ef = 4'((1 << (old + 1)) - 1);
        else if (b)    ef = 4'b0001;
        else           ef = 4'b0000;
        #5;
        if (old >= 0) begin
          chk("R4/R5/R8/R9 flush on fault", {28'h0, flush}, {28'h0, ef});
          chk("R6/R8 next_pc handler", next_pc, HPC);
          chk("R6 pc_sel trap", {30'h0, pc_sel}, 32'd2);
          chk("R6 trap_redirect", {31'h0, trap_redirect}, 32'd1);
          epc_new = exc_pc[old];
        end else if (b) begin
          chk("R1 flush branch", {28'h0, flush}, {28'h0, ef});
          chk("R2 next_pc target", next_pc, br_target);
          chk("R2 pc_sel branch", {30'h0, pc_sel}, 32'd1);
          chk("R6 no trap on branch", {31'h0, trap_redirect}, 32'd0);
          epc_new = exp_epc;
        end else begin
          chk("R3 flush idle", {28'h0, flush}, 32'h0);
          chk("R3 next_pc seq", next_pc, seq_pc);
          chk("R3 pc_sel seq", {30'h0, pc_sel}, 32'd0);
          epc_new = exp_epc;
        end
        chk("R10 rf_we gating", {28'h0, rf_we_out}, {28'h0, rf_we_in & ~ef});
        chk("R10 mem_we gating", {28'h0, mem_we_out}, {28'h0, mem_we_in & ~ef});
        @(posedge clk);
        exp_epc = epc_new;
        #1 chk("R7 fault_pc_q", fault_pc_q, exp_epc);
      end
    end
    @(negedge clk);
    exc_flag = '0; br_redirect = 1'b0;
    rst_n = 1'b0;
    #2 chk("R11 reset clears fault_pc_q", fault_pc_q, 32'h0);
    finish_run();
  end
endmodule